// File: doc/BRIEF.md
# Channel-Tagged Sample Buffer With Threshold

This block gathers 16-bit conversion results from sixteen input channels into a single shared FIFO. Every result is turned into the output number format chosen by software on its way in. It is then stored together with the number of the channel it came from, so the reader can sort a mixed stream back out by channel. A channel announces a result with a one-cycle strobe on its valid line. Each channel has one holding register, so strobes that arrive in the same cycle are written one per cycle, lowest channel first.

The host removes entries through a show-ahead read port. It watches the fill count and three flags: empty, full, and a threshold flag. The threshold flag rises only when the count is strictly greater than a programmed threshold. A gated, level-sensitive interrupt request follows that flag. A write that finds the buffer full is thrown away and sets a sticky overflow bit. A clear command empties the buffer and the holding registers in one cycle. The depth is a parameter.

Top module: `tagged_sample_buffer`

## Requirements
- R1: Each stored entry is 20 bits wide. Bits 19:16 carry the channel number (0 to 15) and bits 15:0 carry the converted sample value.
- R2: Input samples are taken as two's complement. With `fmt_offset` = 0 the value is stored unchanged. With `fmt_offset` = 1 (offset binary) bit 15 is inverted before storing. The format is sampled in the cycle of the strobe.
- R3: Channels strobed in the same cycle are written in ascending channel order, one entry per cycle. No sample is lost as long as the strobes of any one channel are at least 16 cycles apart, including exactly 16.
- R4: Entries leave in the order they were written. `rd_data` always shows the oldest entry. A one-cycle `rd_en` removes it. `rd_en` while the buffer is empty has no effect.
- R5: `fill_count` equals the number of stored entries. `empty` is 1 exactly when the count is 0, and `full` is 1 exactly when the count equals DEPTH.
- R6: `thresh_flag` is 1 exactly when `fill_count` > `thresh`. When the count equals the threshold, the flag stays 0.
- R7: `irq` is a level equal to `irq_en` AND `thresh_flag`.
- R8: A write that arrives while the buffer is full is dropped. Count and contents stay as they were, and `overflow` becomes 1.
- R9: `overflow` stays set until a one-cycle `clr_ovf` pulse clears it. If a new drop happens in the same cycle as the clear, the set wins.
- R10: A one-cycle `clr_buf` pulse makes the next cycle show count 0, `empty` = 1 and `thresh_flag` = 0. Samples still waiting in the holding registers are discarded.
- R11: After reset the buffer is empty, the count is 0, and `thresh_flag`, `irq` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ch_valid | input | NUM_CH | One-cycle result strobe per channel |
| ch_data | input | NUM_CH*DATA_W | Two's complement result per channel; channel c at bits c*DATA_W upward |
| fmt_offset | input | 1 | 1 selects offset binary, 0 selects two's complement |
| thresh | input | CNT_W | Threshold for the count comparison |
| irq_en | input | 1 | Interrupt enable |
| clr_buf | input | 1 | Empty the buffer and the holding registers |
| clr_ovf | input | 1 | Clear the sticky overflow bit |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | DATA_W+TAG_W | Oldest entry: tag over value |
| fill_count | output | CNT_W | Number of stored entries |
| thresh_flag | output | 1 | Count is above the threshold |
| empty | output | 1 | Buffer holds no entries |
| full | output | 1 | Buffer holds DEPTH entries |
| overflow | output | 1 | Sticky: a write was dropped |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a channel's second strobe landing in the very cycle its first sample is being written. That happens only when every channel strobes together and then strobes again exactly 16 cycles later. The bench does exactly this, so channel 15's holding register is reloaded in the same cycle it is granted. It then checks that both values of that channel come out, in order. Overflow is reached by filling the buffer with two full bursts and then strobing once more. A clear is issued one cycle after a full burst, while all sixteen holding registers are still waiting.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } fmt_e;
endpackage

// File: rtl/tsb_ingress.sv
module tsb_ingress
  import tsb_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 4,
  parameter int ENTRY_W = DATA_W + TAG_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_valid,
  input  logic [NUM_CH*DATA_W-1:0] ch_data,
  input  logic                     fmt_offset,
  input  logic                     flush,
  output logic                     wr_req,
  output logic [ENTRY_W-1:0]       wr_entry
);
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] grant;
  logic [DATA_W-1:0] hold_q [NUM_CH];
  logic [DATA_W-1:0] hold_d [NUM_CH];
  logic              found;
  logic [DATA_W-1:0] fmt_mask;

  assign fmt_mask = (fmt_e'(fmt_offset) == FMT_OFFSET) ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  // lowest pending channel wins
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (pend_q[c] && !found) begin
        grant[c] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    wr_entry = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (grant[c]) wr_entry = {TAG_W'(c), hold_q[c]};
    end
  end

  assign wr_req = found && !flush;

  always_comb begin
    pend_d = flush ? '0 : ((pend_q & ~grant) | ch_valid);
    for (int c = 0; c < NUM_CH; c++) begin
      hold_d[c] = ch_valid[c] ? (ch_data[c*DATA_W +: DATA_W] ^ fmt_mask) : hold_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int c = 0; c < NUM_CH; c++) hold_q[c] <= '0;
    end else begin
      pend_q <= pend_d;
      for (int c = 0; c < NUM_CH; c++) hold_q[c] <= hold_d[c];
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R3
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (pend_q == '0)); // R10
endmodule

// File: rtl/tsb_fifo.sv
module tsb_fifo #(
  parameter int DEPTH   = 64,
  parameter int ENTRY_W = 20,
  parameter int CNT_W   = $clog2(DEPTH + 1),
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               rd_req,
  input  logic               clr,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [CNT_W-1:0]   count,
  output logic               empty,
  output logic               full,
  output logic               wr_drop
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               do_wr, do_rd;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_wr   = wr_req && !full && !clr;
  assign do_rd   = rd_req && !empty && !clr;
  assign wr_drop = wr_req && full && !clr;
  assign count   = cnt_q;
  assign rd_data = mem[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      wptr_d = do_wr ? bump(wptr_q) : wptr_q;
      rptr_d = do_rd ? bump(rptr_q) : rptr_q;
      cnt_d  = cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wr_entry;
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CNT_W'(DEPTH)); // R5
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clr |=> empty); // R10
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (wr_drop && !rd_req) |=> (cnt_q == $past(cnt_q))); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (empty && !wr_req && !clr) |=> empty); // R4
endmodule

// File: rtl/tsb_status.sv
module tsb_status #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thresh,
  input  logic             irq_en,
  input  logic             wr_drop,
  input  logic             clr_ovf,
  output logic             thresh_flag,
  output logic             irq,
  output logic             overflow
);
  logic ovf_q, ovf_d;

  assign thresh_flag = (count > thresh);
  assign irq         = irq_en && thresh_flag;
  assign overflow    = ovf_q;

  always_comb begin
    ovf_d = wr_drop | (ovf_q & ~clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_q && !clr_ovf) |=> ovf_q); // R9
  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_ovf && !wr_drop) |=> !ovf_q); // R9
endmodule

// File: rtl/tagged_sample_buffer.sv
module tagged_sample_buffer #(
  parameter int NUM_CH  = 16,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 64,
  localparam int TAG_W   = $clog2(NUM_CH),
  localparam int ENTRY_W = DATA_W + TAG_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_valid,
  input  logic [NUM_CH*DATA_W-1:0] ch_data,
  input  logic                     fmt_offset,
  input  logic [CNT_W-1:0]         thresh,
  input  logic                     irq_en,
  input  logic                     clr_buf,
  input  logic                     clr_ovf,
  input  logic                     rd_en,
  output logic [ENTRY_W-1:0]       rd_data,
  output logic [CNT_W-1:0]         fill_count,
  output logic                     thresh_flag,
  output logic                     empty,
  output logic                     full,
  output logic                     overflow,
  output logic                     irq
);
  logic               wr_req;
  logic [ENTRY_W-1:0] wr_entry;
  logic               wr_drop;

  tsb_ingress #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .TAG_W(TAG_W), .ENTRY_W(ENTRY_W)
  ) u_ingress (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
    .fmt_offset(fmt_offset), .flush(clr_buf), .wr_req(wr_req), .wr_entry(wr_entry)
  );

  tsb_fifo #(
    .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_entry(wr_entry), .rd_req(rd_en),
    .clr(clr_buf), .rd_data(rd_data), .count(fill_count), .empty(empty),
    .full(full), .wr_drop(wr_drop)
  );

  tsb_status #(
    .CNT_W(CNT_W)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .count(fill_count), .thresh(thresh), .irq_en(irq_en),
    .wr_drop(wr_drop), .clr_ovf(clr_ovf), .thresh_flag(thresh_flag), .irq(irq),
    .overflow(overflow)
  );

  AST_FLAG_STRICT: assert property (@(posedge clk) disable iff (!rst_n) thresh_flag |-> (fill_count > thresh)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (irq_en && thresh_flag)); // R7
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n) full |-> !empty); // R5
endmodule

// File: tb/test_tagged_sample_buffer.sv
module test_tagged_sample_buffer;
  localparam int NUM_CH  = 16;
  localparam int DATA_W  = 16;
  localparam int DEPTH   = 32;
  localparam int ENTRY_W = 20;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic                     clk;
  logic                     rst_n;
  logic [NUM_CH-1:0]        ch_valid;
  logic [NUM_CH*DATA_W-1:0] ch_data;
  logic                     fmt_offset;
  logic [CNT_W-1:0]         thresh;
  logic                     irq_en;
  logic                     clr_buf;
  logic                     clr_ovf;
  logic                     rd_en;
  logic [ENTRY_W-1:0]       rd_data;
  logic [CNT_W-1:0]         fill_count;
  logic                     thresh_flag, empty, full, overflow, irq;

  int vectors;
  int misses;
  logic [ENTRY_W-1:0] model_q[$];
  logic               model_ovf;

  tagged_sample_buffer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEPTH(DEPTH)) i_tagged_sample_buffer (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data), .fmt_offset(fmt_offset),
    .thresh(thresh), .irq_en(irq_en), .clr_buf(clr_buf), .clr_ovf(clr_ovf), .rd_en(rd_en),
    .rd_data(rd_data), .fill_count(fill_count), .thresh_flag(thresh_flag), .empty(empty),
    .full(full), .overflow(overflow), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sample(input int c, input int k);
    return 16'((c * 4099) + (k * 2617) + 16'h7F31);
  endfunction

  // drive one strobe cycle, update model; caller waits afterwards
  task automatic strobe(input logic [NUM_CH-1:0] mask, input int k);
    ch_valid = mask;
    for (int c = 0; c < NUM_CH; c++) begin
      logic [15:0] v;
      v = (k < 0) ? ((c % 4 == 0) ? 16'h8000 : (c % 4 == 1) ? 16'h7FFF : (c % 4 == 2) ? 16'h0000 : 16'hFFFF)
                  : sample(c, k);
      ch_data[c*DATA_W +: DATA_W] = v;
      if (mask[c]) begin
        if (model_q.size() < DEPTH) model_q.push_back({4'(c), v ^ (fmt_offset ? 16'h8000 : 16'h0000)});
        else model_ovf = 1'b1;
      end
    end
    tick(1);
    ch_valid = '0;
  endtask

  task automatic check_status(input string req);
    chk({req, " count"}, 32'(fill_count), 32'(model_q.size()));
    chk({req, " empty"}, 32'(empty), 32'(model_q.size() == 0));
    chk({req, " full"}, 32'(full), 32'(model_q.size() == DEPTH));
    chk({req, " flag"}, 32'(thresh_flag), 32'(model_q.size() > int'(thresh)));
    chk({req, " irq"}, 32'(irq), 32'(irq_en && (model_q.size() > int'(thresh))));
    chk({req, " overflow"}, 32'(overflow), 32'(model_ovf));
  endtask

  task automatic drain(input string req);
    while (model_q.size() > 0) begin
      logic [ENTRY_W-1:0] e;
      e = model_q.pop_front();
      chk({req, " tag"}, 32'(rd_data[19:16]), 32'(e[19:16]));
      chk({req, " value"}, 32'(rd_data[15:0]), 32'(e[15:0]));
      rd_en = 1'b1;
      tick(1);
      rd_en = 1'b0;
    end
  endtask

  task automatic pulse_clr();
    clr_buf = 1'b1;
    tick(1);
    clr_buf = 1'b0;
    model_q.delete();
  endtask

  initial begin
    vectors = 0;
    misses = 0;
    model_ovf = 1'b0;
    rst_n = 1'b0;
    ch_valid = '0;
    ch_data = '0;
    fmt_offset = 1'b0;
    thresh = CNT_W'(DEPTH);
    irq_en = 1'b1;
    clr_buf = 1'b0;
    clr_ovf = 1'b0;
    rd_en = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check_status("R11 reset");

    // R1 R2: each channel alone, two's complement, corner values then patterns
    for (int c = 0; c < NUM_CH; c++) begin
      strobe(NUM_CH'(1) << c, (c < 8) ? -1 : c);
      tick(3);
      check_status("R5 single");
    end
    drain("R1 R2 R4 twos");
    check_status("R4 drained");

    // R3 back-to-back rounds exactly 16 cycles apart, offset binary
    fmt_offset = 1'b1;
    strobe('1, -1);
    tick(15);
    strobe('1, 5);
    tick(20);
    check_status("R3 R5 full");
    // R8 write into full buffer
    strobe(16'h0020, 9);
    tick(4);
    check_status("R8 drop");
    drain("R3 R2 offset order");
    // R4 read while empty is ignored
    rd_en = 1'b1;
    tick(2);
    rd_en = 1'b0;
    check_status("R4 empty read");
    // R9 clear overflow
    clr_ovf = 1'b1;
    tick(1);
    clr_ovf = 1'b0;
    model_ovf = 1'b0;
    check_status("R9 ovf clear");

    // R6 R7 threshold sweep with strict compare
    for (int t = 0; t < 5; t++) begin
      thresh = CNT_W'((t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 15 : (t == 3) ? 31 : 32);
      irq_en = t[0];
      pulse_clr();
      for (int i = 0; i < DEPTH; i++) begin
        strobe(NUM_CH'(1) << (i % NUM_CH), i + t * 40);
        tick(2);
        check_status("R6 R7 sweep");
      end
      // R10 clear: status visible the very next cycle
      pulse_clr();
      check_status("R10 clear");
    end

    // R10 clear while all holding registers are waiting
    irq_en = 1'b1;
    thresh = '0;
    ch_valid = '1;
    tick(1);
    ch_valid = '0;
    clr_buf = 1'b1;
    tick(1);
    clr_buf = 1'b0;
    tick(20);
    check_status("R10 pending flush");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule